// File: doc/BRIEF.md
# Single Write-Port Scheduler for a Five-Stage Pipeline

This block is the hazard control for one register-file write port in a five-stage in-order pipeline (fetch, decode/register read, execute, memory, write-back). It accepts at most one instruction per cycle. Each instruction carries a class, a destination register number and a result tag. The block moves each instruction through five stage registers and presents its write on a single registered write port in the right cycle.

A load writes in its fifth stage. An R-type writes in its fourth stage when left alone. A load followed directly by an R-type would therefore claim the port twice in one cycle. A run-time mode input selects how this is avoided:
- **Hold mode (0):** the R-type is held back for one cycle and an empty slot enters the pipeline in its place.
- **Late mode (1):** every R-type postpones its write to the fifth stage. No slot is ever lost.

The mode may only change while the pipeline is empty. While the stall output is high, the upstream source keeps the same instruction on its inputs. A conflict output reports any cycle in which two writes were due at once; it serves as a checking aid.

Top module: `wport_arbiter`

## Requirements
- R1: While reset is high at a clock edge, every stage becomes empty. After that edge, wr_en and wr_conflict are low, and no instruction accepted before reset ever produces a write.
- R2: In hold mode (mode=0), an R-type (class 2'b10) accepted at edge k appears on wr_en/wr_addr/wr_data with its own destination and tag during the cycle after edge k+3.
- R3: A load (class 2'b01) accepted at edge k appears on the write port during the cycle after edge k+4, in either mode.
- R4: In late mode (mode=1), an R-type accepted at edge k appears on the write port during the cycle after edge k+4.
- R5: A store (class 2'b11) or an empty slot (class 2'b00) never produces a write; wr_en is low in any cycle with no write due.
- R6: In hold mode, issue_stall is high exactly when the input class is R-type and the instruction accepted at the previous edge was a load. An edge with issue_stall high accepts nothing.
- R7: In late mode, issue_stall is never high, and an instruction is accepted at every edge.
- R8: An instruction held during a stall is accepted at the following edge. It is written exactly once, with its own destination and tag.
- R9: wr_conflict never rises, and at most one write is presented per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 = hold (bubble) policy, 1 = late R-type write policy |
| in_cls | input | 2 | Incoming class: 00 none, 01 load, 10 R-type, 11 store |
| in_dest | input | AW (5) | Destination register of the incoming instruction |
| in_tag | input | DW (32) | Result tag of the incoming instruction |
| issue_stall | output | 1 | High when the incoming instruction is not accepted this cycle |
| wr_en | output | 1 | Register-file write enable (registered) |
| wr_addr | output | AW (5) | Write register number (registered) |
| wr_data | output | DW (32) | Write data, the instruction's tag (registered) |
| wr_conflict | output | 1 | High in the cycle after two writes were due together |

## Verification
A stage register holding a wrong class or a wrong late-write bit shows up at the write port within four or five cycles of the instruction's acceptance. The symptom is a write in the wrong cycle, a missing write, or a tag on the wrong destination. A bad stage-one class shows at once on issue_stall, in the same cycle the following instruction is presented. Because every accepted tag is random, a duplicated or dropped held instruction is seen as an extra or missing write with a specific tag.

// File: rtl/wpa_pkg.sv
package wpa_pkg;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'b00,
    CLS_LOAD  = 2'b01,
    CLS_ALU   = 2'b10,
    CLS_STORE = 2'b11
  } icls_e;

  function automatic logic cls_writes(input icls_e c);
    return (c == CLS_LOAD) || (c == CLS_ALU);
  endfunction

endpackage

// File: rtl/wpa_issue_gate.sv
module wpa_issue_gate
  import wpa_pkg::*;
(
  input  logic  mode,
  input  icls_e in_cls,
  input  icls_e s1_cls,
  output logic  stall,
  output logic  accept,
  output logic  late
);

  // An R-type directly behind a load would write one cycle earlier in its
  // life, i.e. in the same cycle as that load. Hold it in hold mode only.
  always_comb begin
    stall  = !mode && (in_cls == CLS_ALU) && (s1_cls == CLS_LOAD);
    accept = !stall;
    late   = (in_cls == CLS_LOAD) || ((in_cls == CLS_ALU) && mode);
  end

endmodule

// File: rtl/wpa_stage_chain.sv
module wpa_stage_chain
  import wpa_pkg::*;
#(
  parameter int NSTAGE = 5,
  parameter int AW     = 5,
  parameter int DW     = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  icls_e         in_cls,
  input  logic [AW-1:0] in_dest,
  input  logic [DW-1:0] in_tag,
  input  logic          in_late,
  output icls_e         st_cls  [NSTAGE],
  output logic [AW-1:0] st_dest [NSTAGE],
  output logic [DW-1:0] st_tag  [NSTAGE],
  output logic          st_late [NSTAGE]
);

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    if (k == 0) begin : g_entry
      always_ff @(posedge clk) begin
        if (rst) begin
          st_cls[0]  <= CLS_NONE;
          st_late[0] <= 1'b0;
        end else if (accept) begin
          st_cls[0]  <= in_cls;
          st_late[0] <= in_late;
        end else begin
          st_cls[0]  <= CLS_NONE;
          st_late[0] <= 1'b0;
        end
      end
      always_ff @(posedge clk) begin
        st_dest[0] <= in_dest;
        st_tag[0]  <= in_tag;
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (rst) begin
          st_cls[k]  <= CLS_NONE;
          st_late[k] <= 1'b0;
        end else begin
          st_cls[k]  <= st_cls[k-1];
          st_late[k] <= st_late[k-1];
        end
      end
      always_ff @(posedge clk) begin
        st_dest[k] <= st_dest[k-1];
        st_tag[k]  <= st_tag[k-1];
      end
    end
  end

endmodule

// File: rtl/wpa_wport.sv
module wpa_wport
  import wpa_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  icls_e         early_cls,
  input  logic          early_late,
  input  logic [AW-1:0] early_dest,
  input  logic [DW-1:0] early_tag,
  input  icls_e         late_cls,
  input  logic          late_late,
  input  logic [AW-1:0] late_dest,
  input  logic [DW-1:0] late_tag,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          conflict
);

  logic early_req;
  logic late_req;

  // early_* is the instruction about to enter stage 4, late_* the one about
  // to enter stage 5; the registered port then reflects that stage's write.
  always_comb begin
    early_req = (early_cls == CLS_ALU) && !early_late;
    late_req  = cls_writes(late_cls) && late_late;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en    <= 1'b0;
      conflict <= 1'b0;
    end else begin
      wr_en    <= early_req || late_req;
      conflict <= early_req && late_req;
    end
  end

  always_ff @(posedge clk) begin
    if (late_req) begin
      wr_addr <= late_dest;
      wr_data <= late_tag;
    end else begin
      wr_addr <= early_dest;
      wr_data <= early_tag;
    end
  end

endmodule

// File: rtl/wport_arbiter.sv
module wport_arbiter
  import wpa_pkg::*;
#(
  parameter int NSTAGE = 5,
  parameter int AW     = 5,
  parameter int DW     = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode,
  input  logic [1:0]    in_cls,
  input  logic [AW-1:0] in_dest,
  input  logic [DW-1:0] in_tag,
  output logic          issue_stall,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_conflict
);

  localparam int EARLY_SRC = NSTAGE - 3;
  localparam int LATE_SRC  = NSTAGE - 2;

  icls_e         cls_in;
  logic          accept;
  logic          late_bit;
  icls_e         st_cls  [NSTAGE];
  logic [AW-1:0] st_dest [NSTAGE];
  logic [DW-1:0] st_tag  [NSTAGE];
  logic          st_late [NSTAGE];

  assign cls_in = icls_e'(in_cls);

  wpa_issue_gate u_gate (
    .mode   (mode),
    .in_cls (cls_in),
    .s1_cls (st_cls[0]),
    .stall  (issue_stall),
    .accept (accept),
    .late   (late_bit)
  );

  wpa_stage_chain #(.NSTAGE(NSTAGE), .AW(AW), .DW(DW)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .accept  (accept),
    .in_cls  (cls_in),
    .in_dest (in_dest),
    .in_tag  (in_tag),
    .in_late (late_bit),
    .st_cls  (st_cls),
    .st_dest (st_dest),
    .st_tag  (st_tag),
    .st_late (st_late)
  );

  wpa_wport #(.AW(AW), .DW(DW)) u_wport (
    .clk        (clk),
    .rst        (rst),
    .early_cls  (st_cls[EARLY_SRC]),
    .early_late (st_late[EARLY_SRC]),
    .early_dest (st_dest[EARLY_SRC]),
    .early_tag  (st_tag[EARLY_SRC]),
    .late_cls   (st_cls[LATE_SRC]),
    .late_late  (st_late[LATE_SRC]),
    .late_dest  (st_dest[LATE_SRC]),
    .late_tag   (st_tag[LATE_SRC]),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .conflict   (wr_conflict)
  );

endmodule

// File: rtl/wport_arbiter_chk.sv
module wport_arbiter_chk (
  input logic       clk,
  input logic       rst,
  input logic       mode,
  input logic [1:0] in_cls,
  input logic       issue_stall,
  input logic       wr_en,
  input logic       wr_conflict
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!wr_en && !wr_conflict));

  assert_no_conflict_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_conflict);

  assert_late_never_stalls_R7: assert property (@(posedge clk) disable iff (rst)
    mode |-> !issue_stall);

  assert_stall_only_alu_R6: assert property (@(posedge clk) disable iff (rst)
    issue_stall |-> (in_cls == 2'b10 && !mode));

  assert_stall_single_R8: assert property (@(posedge clk) disable iff (rst)
    issue_stall |=> !issue_stall);

  assert_load_writes_R3: assert property (@(posedge clk) disable iff (rst)
    (in_cls == 2'b01 && !issue_stall) |-> ##5 wr_en);

endmodule

bind wport_arbiter wport_arbiter_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode        (mode),
  .in_cls      (in_cls),
  .issue_stall (issue_stall),
  .wr_en       (wr_en),
  .wr_conflict (wr_conflict)
);

// File: tb/sim_wport_arbiter.sv
`timescale 1ns/1ps
module sim_wport_arbiter;

  localparam int AW = 5;
  localparam int DW = 32;
  localparam int RING = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode = 1'b0;
  logic [1:0]    in_cls = 2'b00;
  logic [AW-1:0] in_dest = '0;
  logic [DW-1:0] in_tag = '0;
  logic          issue_stall;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          wr_conflict;

  int checks = 0;
  int fails = 0;
  int ec = 0;
  logic prev_load = 1'b0;
  logic saw_stall = 1'b0;

  logic          exp_en   [RING];
  logic [AW-1:0] exp_addr [RING];
  logic [DW-1:0] exp_data [RING];
  string         exp_req  [RING];

  always #2.5 clk = ~clk;

  wport_arbiter #(.NSTAGE(5), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .mode(mode), .in_cls(in_cls), .in_dest(in_dest),
    .in_tag(in_tag), .issue_stall(issue_stall), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_conflict(wr_conflict)
  );

  function automatic logic want_stall(input logic m, input logic [1:0] c, input logic pl);
    return !m && (c == 2'b10) && pl;
  endfunction

  function automatic int write_delay(input logic m, input logic [1:0] c);
    if (c == 2'b01) return 4;
    if (c == 2'b10) return m ? 4 : 3;
    return -1;
  endfunction

  function automatic string write_req(input logic m, input logic [1:0] c);
    if (c == 2'b01) return "R3";
    return m ? "R4" : "R2";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at edge %0d", req, what, act, exp, ec);
    end
  endtask

  task automatic clear_ring();
    for (int i = 0; i < RING; i++) begin
      exp_en[i] = 1'b0;
      exp_addr[i] = '0;
      exp_data[i] = '0;
      exp_req[i] = "R5";
    end
  endtask

  // Called at a negedge: present one instruction, check stall, advance one edge,
  // then check the write port for the edge just taken.
  task automatic cyc(input logic [1:0] c, input logic [AW-1:0] d,
                     input logic [DW-1:0] t, input bit held, output bit acc);
    logic es;
    logic next_load;
    int dly;
    int slot;
    in_cls = c; in_dest = d; in_tag = t;
    #1;
    es = rst ? 1'b0 : want_stall(mode, c, prev_load);
    if (!rst)
      check(issue_stall == es, mode ? "R7" : "R6", "issue_stall", issue_stall, es);
    if (issue_stall) saw_stall = 1'b1;
    acc = !es;
    next_load = 1'b0;
    if (!rst && acc) begin
      next_load = (c == 2'b01);
      dly = write_delay(mode, c);
      if (dly >= 0) begin
        slot = (ec + 1 + dly) % RING;
        check(!exp_en[slot], "R9", "bench double booking", 1, 0);
        exp_en[slot] = 1'b1;
        exp_addr[slot] = d;
        exp_data[slot] = t;
        exp_req[slot] = held ? "R8" : write_req(mode, c);
      end
    end
    @(posedge clk);
    ec++;
    prev_load = next_load;
    @(negedge clk);
    slot = ec % RING;
    if (rst) begin
      check(!wr_en, "R1", "wr_en in reset", wr_en, 0);
      check(!wr_conflict, "R1", "conflict in reset", wr_conflict, 0);
    end else begin
      check(wr_en == exp_en[slot], exp_en[slot] ? exp_req[slot] : "R5", "wr_en", wr_en, exp_en[slot]);
      if (exp_en[slot] && wr_en) begin
        check(wr_addr == exp_addr[slot], exp_req[slot], "wr_addr", wr_addr, exp_addr[slot]);
        check(wr_data == exp_data[slot], exp_req[slot], "wr_data", wr_data, exp_data[slot]);
      end
      check(!wr_conflict, "R9", "wr_conflict", wr_conflict, 0);
    end
    exp_en[slot] = 1'b0;
  endtask

  task automatic issue(input logic [1:0] c, input logic [AW-1:0] d, input logic [DW-1:0] t);
    bit acc;
    bit held;
    held = 1'b0;
    cyc(c, d, t, held, acc);
    while (!acc) begin
      held = 1'b1;
      cyc(c, d, t, held, acc);
    end
  endtask

  task automatic do_reset(input int n);
    bit acc;
    rst = 1'b1;
    clear_ring();
    prev_load = 1'b0;
    for (int i = 0; i < n; i++) cyc(2'b00, '0, '0, 1'b0, acc);
    rst = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 7; i++) issue(2'b00, '0, '0);
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++)
      issue(2'($urandom_range(0, 3)), AW'($urandom), DW'($urandom));
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c1a));
    clear_ring();
    @(negedge clk);
    do_reset(3);
    // R1: idle after reset
    check(!wr_en && !issue_stall, "R1", "idle after reset", {wr_en, issue_stall}, 0);

    // R6/R8: load then R-type in hold mode loses one slot
    mode = 1'b0;
    saw_stall = 1'b0;
    issue(2'b01, 5'd3, 32'hAAAA_0001);
    issue(2'b10, 5'd4, 32'hBBBB_0002);
    check(saw_stall, "R6", "stall seen for load->R-type", saw_stall, 1);
    // R-type then load, store: no stall
    saw_stall = 1'b0;
    issue(2'b10, 5'd5, 32'hCCCC_0003);
    issue(2'b01, 5'd6, 32'hDDDD_0004);
    issue(2'b11, 5'd7, 32'hEEEE_0005);
    check(!saw_stall, "R6", "no stall for R-type->load", saw_stall, 0);
    drain();

    // R7: late mode, back-to-back load/R-type never stalls
    mode = 1'b1;
    saw_stall = 1'b0;
    for (int i = 0; i < 8; i++)
      issue((i % 2 == 0) ? 2'b01 : 2'b10, 5'(i), 32'h1000_0000 + 32'(i));
    check(!saw_stall, "R7", "late mode stall count", saw_stall, 0);
    drain();

    // random traffic in each mode
    mode = 1'b0;
    random_run(3000);
    drain();
    mode = 1'b1;
    random_run(3000);
    drain();

    // R1: reset with writes in flight removes them
    mode = 1'b0;
    issue(2'b01, 5'd9, 32'h1234_5678);
    issue(2'b10, 5'd10, 32'h8765_4321);
    do_reset(1);
    drain();

    mode = 1'b0;
    random_run(1000);
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule